// File: doc/BRIEF.md
# Two/Four-Level FSK Symbol Path with Clock Recovery

This block carries hard-decision FSK symbols from a receiver front end into a byte-wide register that a processor can read. Every register in it runs from the 76.8 kHz sample clock. Each symbol is either one bit (2-level) or two bits (4-level). The symbols come from one of two sources. The first is the decision bits of an on-chip demodulator. The second is a pair of external NRZ pins, with the MSB on one pin and the LSB on the other. A two-bit mode selection picks one of three paths:

- demodulator decisions;
- the external pins cleaned by a three-sample majority vote;
- the external pins passed through raw.

The selected stream feeds a digital clock recovery loop. The loop is a phase accumulator that advances by a programmable step on every sample. Each data transition pulls the phase a fixed fraction of the way toward the point half a symbol away from the sampling instant. On each wrap of the accumulator, the current symbol is shifted into a byte assembler. Whenever a full byte is complete, the block loads the symbol register and pulses a ready strobe. A separate enable switches off the demodulator source, and another holds the recovery loop and the assembler idle.

Top module: `fsk_symbol_path`

## Requirements
- R1: While `rst` is high, `sym_reg` reads zero and both `sym_ready` and `rec_clk` read low on the cycle after each clock edge.
- R2: Mode bits choose the source. With `mode_m`=0, the demodulator decision bits are used and `mode_bf` is ignored. With `mode_m`=1 and `mode_bf`=1, the raw pins are used, with `pin_i` as the symbol MSB and `pin_q` as the LSB.
- R3: With `mode_m`=1 and `mode_bf`=0, each symbol bit is the majority of its last three samples, so an isolated one-sample glitch never reaches the recovered data.
- R4: In demodulator mode with `demod_en` low, the symbol stream is forced to 00, so every assembled byte is 0x00.
- R5: In 2-level mode (`four_level`=0) each symbol contributes only its MSB, one bit per symbol. The LSB input (`pin_q` or `dem_d0`) has no effect on `sym_reg`.
- R6: In 4-level mode, each symbol contributes two bits, MSB first. Within a byte, the oldest symbol sits in the top bits of `sym_reg`.
- R7: `sym_ready` is a one-cycle pulse raised each time 8 new bits have been assembled. `sym_reg` changes only in that cycle. With no transitions, pulses are 8·256/`baud_step` cycles apart in 2-level mode and 4·256/`baud_step` cycles apart in 4-level mode.
- R8: `rec_clk` is the top bit of the 8-bit phase accumulator. With no data transitions, it completes one period every 256/`baud_step` samples.
- R9: Each data transition moves the phase by a quarter of its distance from mid-scale. This keeps the sampling locked to data whose symbol period differs from 256/`baud_step` by a few percent.
- R10: While `rec_en` is low, the phase, the bit count and the registers are held cleared. From the next cycle on, `sym_ready`, `rec_clk` and `sym_reg` stay at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 76.8 kHz sample clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_m | input | 1 | 0: demodulator source; 1: external pins |
| mode_bf | input | 1 | With `mode_m`=1: 0 majority filter, 1 raw |
| four_level | input | 1 | 1: 2-bit symbols; 0: 1-bit symbols |
| demod_en | input | 1 | Enables the demodulator decision source |
| rec_en | input | 1 | Enables clock recovery and byte assembly |
| baud_step | input | 8 | Phase increment per sample (256/step samples per symbol) |
| dem_d1 | input | 1 | Demodulator decision MSB |
| dem_d0 | input | 1 | Demodulator decision LSB |
| pin_i | input | 1 | External NRZ data, symbol MSB |
| pin_q | input | 1 | External NRZ data, symbol LSB |
| sym_reg | output | 8 | Last completed byte of recovered symbols |
| sym_ready | output | 1 | One-cycle pulse when `sym_reg` is loaded |
| rec_clk | output | 1 | Recovered symbol clock |

## Verification
The bench builds the block with its default parameters: an 8-bit phase, a nudge shift of 2 and an 8-bit symbol register. It drives `baud_step` values of 32, 64 and 31. The value 32 gives 8-sample symbols, long enough for single-sample glitches in the middle of a symbol and for a settled sampling point. The value 64 checks that the recovered clock period scales with the step. The value 31 against 8-sample data brings a drift of about three percent within reach. A loop without the transition nudge would slip whole symbols within a few bytes under that drift.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

    typedef enum logic [1:0] {
        PATH_DEMOD  = 2'd0,
        PATH_FILTER = 2'd1,
        PATH_DIRECT = 2'd2
    } path_e;

    typedef struct packed {
        logic msb;
        logic lsb;
    } sym_t;

    function automatic path_e pick_path(input logic m, input logic bf);
        if (!m)
            return PATH_DEMOD;
        return bf ? PATH_DIRECT : PATH_FILTER;
    endfunction

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/fsk_path_select.sv
module fsk_path_select
    import fsk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  path_e path,
    input  logic  four_level,
    input  logic  demod_en,
    input  sym_t  dem_sym,
    input  sym_t  pin_sym,
    output sym_t  sym_out
);
    localparam int LANES = $bits(sym_t);

    logic [LANES-1:0] src;
    logic [LANES-1:0] hist0, hist1, hist2;
    logic [LANES-1:0] voted;

    always_comb begin
        case (path)
            PATH_DEMOD: src = demod_en ? dem_sym : '0;
            default:    src = pin_sym;
        endcase
        if (!four_level)
            src[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist0 <= '0;
            hist1 <= '0;
            hist2 <= '0;
        end else begin
            hist0 <= src;
            hist1 <= hist0;
            hist2 <= hist1;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_vote
        assign voted[g] = maj3(hist0[g], hist1[g], hist2[g]);
    end

    assign sym_out = (path == PATH_FILTER) ? voted : hist0;

endmodule

// File: rtl/fsk_clock_recovery.sv
module fsk_clock_recovery
    import fsk_pkg::*;
#(
    parameter int PHASE_W  = 8,
    parameter int NUDGE_SH = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [PHASE_W-1:0] step,
    input  sym_t               data_in,
    output logic               strobe,
    output logic               rec_clk
);
    localparam int EXT_W = PHASE_W + 2;
    localparam logic signed [EXT_W-1:0] FULL = {2'b01, {PHASE_W{1'b0}}};
    localparam logic signed [EXT_W-1:0] MID  = {3'b001, {(PHASE_W-1){1'b0}}};

    logic [PHASE_W-1:0]      phase_q;
    sym_t                    prev_q;
    logic signed [EXT_W-1:0] phase_ext, err, corr, next_ext;
    logic                    wrap;

    always_comb begin
        phase_ext = $signed({2'b00, phase_q});
        err       = phase_ext - MID;
        corr      = (data_in != prev_q) ? (err >>> NUDGE_SH) : '0;
        next_ext  = phase_ext + $signed({2'b00, step}) - corr;
        wrap      = (next_ext >= FULL);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            phase_q <= '0;
            prev_q  <= data_in;
        end else begin
            phase_q <= next_ext[PHASE_W-1:0];
            prev_q  <= data_in;
        end
    end

    assign strobe  = enable && !rst && wrap;
    assign rec_clk = phase_q[PHASE_W-1];

endmodule

// File: rtl/fsk_symbol_shift.sv
module fsk_symbol_shift
    import fsk_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              strobe,
    input  logic              four_level,
    input  sym_t              data_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic              ready
);
    localparam int CNT_W = $clog2(BYTE_W) + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    logic [BYTE_W-1:0] shift_q, shifted;
    logic [CNT_W-1:0]  cnt_q, cnt_next;

    always_comb begin
        if (four_level) begin
            shifted  = {shift_q[BYTE_W-3:0], data_in.msb, data_in.lsb};
            cnt_next = cnt_q + CNT_W'(2);
        end else begin
            shifted  = {shift_q[BYTE_W-2:0], data_in.msb};
            cnt_next = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            shift_q  <= '0;
            cnt_q    <= '0;
            byte_out <= '0;
            ready    <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (strobe) begin
                shift_q <= shifted;
                if (cnt_next >= FULL_CNT) begin
                    byte_out <= shifted;
                    ready    <= 1'b1;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_next;
                end
            end
        end
    end

endmodule

// File: rtl/fsk_symbol_path.sv
module fsk_symbol_path
    import fsk_pkg::*;
#(
    parameter int PHASE_W  = 8,
    parameter int NUDGE_SH = 2,
    parameter int BYTE_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_m,
    input  logic               mode_bf,
    input  logic               four_level,
    input  logic               demod_en,
    input  logic               rec_en,
    input  logic [PHASE_W-1:0] baud_step,
    input  logic               dem_d1,
    input  logic               dem_d0,
    input  logic               pin_i,
    input  logic               pin_q,
    output logic [BYTE_W-1:0]  sym_reg,
    output logic               sym_ready,
    output logic               rec_clk
);
    path_e path;
    sym_t  dem_sym, pin_sym, sel_sym;
    logic  strobe;

    assign path    = pick_path(mode_m, mode_bf);
    assign dem_sym = '{msb: dem_d1, lsb: dem_d0};
    assign pin_sym = '{msb: pin_i, lsb: pin_q};

    fsk_path_select u_path (
        .clk        (clk),
        .rst        (rst),
        .path       (path),
        .four_level (four_level),
        .demod_en   (demod_en),
        .dem_sym    (dem_sym),
        .pin_sym    (pin_sym),
        .sym_out    (sel_sym)
    );

    fsk_clock_recovery #(
        .PHASE_W  (PHASE_W),
        .NUDGE_SH (NUDGE_SH)
    ) u_rec (
        .clk     (clk),
        .rst     (rst),
        .enable  (rec_en),
        .step    (baud_step),
        .data_in (sel_sym),
        .strobe  (strobe),
        .rec_clk (rec_clk)
    );

    fsk_symbol_shift #(
        .BYTE_W (BYTE_W)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .enable     (rec_en),
        .strobe     (strobe),
        .four_level (four_level),
        .data_in    (sel_sym),
        .byte_out   (sym_reg),
        .ready      (sym_ready)
    );

endmodule

// File: rtl/fsk_symbol_path_chk.sv
module fsk_symbol_path_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rec_en,
    input logic [BYTE_W-1:0] sym_reg,
    input logic              sym_ready,
    input logic              rec_clk
);
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rec_en |=> (!sym_ready && !rec_clk && sym_reg == '0)); // R10

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        sym_ready |=> !sym_ready); // R7

    AST_REG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rec_en && $past(rec_en) && !sym_ready) |-> $stable(sym_reg)); // R7

    AST_CLK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(rec_clk) |-> $past(rec_en)); // R8

endmodule

bind fsk_symbol_path fsk_symbol_path_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rec_en    (rec_en),
    .sym_reg   (sym_reg),
    .sym_ready (sym_ready),
    .rec_clk   (rec_clk)
);

// File: tb/fsk_symbol_path_test.sv
module fsk_symbol_path_test;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_m = 1'b1, mode_bf = 1'b1, four_level = 1'b0;
    logic       demod_en = 1'b0, rec_en = 1'b0;
    logic [7:0] baud_step = 8'd32;
    logic       dem_d1 = 1'b0, dem_d0 = 1'b0, pin_i = 1'b0, pin_q = 1'b0;
    logic [7:0] sym_reg;
    logic       sym_ready, rec_clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [1:0] tx [0:255];
    logic [7:0] rx [0:63];
    int  rx_count = 0;
    bit  collecting = 1'b0;

    fsk_symbol_path uut (
        .clk(clk), .rst(rst), .mode_m(mode_m), .mode_bf(mode_bf),
        .four_level(four_level), .demod_en(demod_en), .rec_en(rec_en),
        .baud_step(baud_step), .dem_d1(dem_d1), .dem_d0(dem_d0),
        .pin_i(pin_i), .pin_q(pin_q), .sym_reg(sym_reg),
        .sym_ready(sym_ready), .rec_clk(rec_clk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cycles++;
        if (collecting && sym_ready && rx_count < 64) begin
            rx[rx_count] = sym_reg;
            rx_count++;
        end
        if (cycles > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_at(input int base, input bit lev);
        logic [7:0] b = '0;
        int spb = lev ? 4 : 8;
        for (int i = 0; i < spb; i++)
            b = lev ? {b[5:0], tx[base+i]} : {b[6:0], tx[base+i][1]};
        return b;
    endfunction

    // Finds one symbol offset for which every settled byte matches the sent symbols.
    function automatic bit stream_matches(input bit lev, input int nsym);
        int spb = lev ? 4 : 8;
        for (int o = 0; o < 64; o++) begin
            bit ok = 1'b1;
            int used = 0;
            for (int k = 2; k < rx_count; k++) begin
                int base = o + (k - 2) * spb;
                if (base + spb > nsym) break;
                if (byte_at(base, lev) != rx[k]) ok = 1'b0;
                used++;
            end
            if (ok && used >= 3) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic configure(input bit m, input bit bf, input bit lev, input bit den,
                             input logic [7:0] step);
        rec_en = 1'b0;
        mode_m = m; mode_bf = bf; four_level = lev; demod_en = den; baud_step = step;
        repeat (3) @(negedge clk);
    endtask

    // 8 samples per symbol; optional one-sample glitch and forced frequent transitions.
    task automatic run_stream(input bit lev, input bit use_dem, input int nsym,
                              input bit glitch, input bit busy);
        for (int j = 0; j < nsym; j++) begin
            logic [1:0] v = 2'($urandom);
            if (busy && j > 0 && ($urandom % 4) != 0)
                v = lev ? (tx[j-1] ^ 2'(1 + $urandom % 3)) : {~tx[j-1][1], 1'b0};
            if (!lev) v[0] = 1'b0;
            tx[j] = v;
        end
        rx_count = 0;
        collecting = 1'b1;
        rec_en = 1'b1;
        for (int j = 0; j < nsym; j++) begin
            int gpos = 2 + ($urandom % 4);
            for (int s = 0; s < 8; s++) begin
                logic [1:0] d = tx[j];
                if (glitch && s == gpos) d = d ^ (lev ? 2'b11 : 2'b10);
                if (!lev) d[0] = 1'($urandom);
                if (use_dem) begin
                    {dem_d1, dem_d0} = d;
                    {pin_i, pin_q} = 2'($urandom);
                end else begin
                    {pin_i, pin_q} = d;
                    {dem_d1, dem_d0} = 2'($urandom);
                end
                @(negedge clk);
            end
        end
        collecting = 1'b0;
    endtask

    task automatic ready_gap(input bit lev, input int exp, input string req);
        int c = 0;
        configure(1'b1, 1'b1, lev, 1'b0, 8'd32);
        {pin_i, pin_q} = 2'b10;
        rec_en = 1'b1;
        while (!sym_ready && c < 500) begin @(negedge clk); c++; end
        c = 0;
        do begin @(negedge clk); c++; end while (!sym_ready && c < 500);
        chk(c == exp, req, c, exp);
    endtask

    task automatic clk_rises(input logic [7:0] step, input int exp);
        int rises = 0;
        logic prev;
        configure(1'b1, 1'b1, 1'b0, 1'b0, step);
        {pin_i, pin_q} = 2'b00;
        rec_en = 1'b1;
        repeat (16) @(negedge clk);
        prev = rec_clk;
        repeat (256) begin
            @(negedge clk);
            if (rec_clk && !prev) rises++;
            prev = rec_clk;
        end
        chk(rises == exp, "R8 rec_clk rises in 256 samples", rises, exp);
    endtask

    initial begin
        bit all_zero;
        int bad;
        void'($urandom(32'd5010));
        rec_en = 1'b1;
        repeat (4) @(negedge clk);
        chk(sym_reg == 8'h00, "R1 sym_reg in reset", sym_reg, 0);
        chk(sym_ready == 1'b0, "R1 sym_ready in reset", sym_ready, 0);
        chk(rec_clk == 1'b0, "R1 rec_clk in reset", rec_clk, 0);
        rst = 1'b0;

        // R2 R5: raw pins, 2-level, LSB pin randomised
        configure(1'b1, 1'b1, 1'b0, 1'b0, 8'd32);
        run_stream(1'b0, 1'b0, 96, 1'b0, 1'b0);
        chk(stream_matches(1'b0, 96), "R2 R5 direct 2-level bytes", rx[2], byte_at(0, 1'b0));

        // R2 R6: raw pins, 4-level, MSB first
        configure(1'b1, 1'b1, 1'b1, 1'b0, 8'd32);
        run_stream(1'b1, 1'b0, 64, 1'b0, 1'b0);
        chk(stream_matches(1'b1, 64), "R6 direct 4-level bytes", rx[2], byte_at(0, 1'b1));

        // R2: demodulator source with mode_bf set high (ignored)
        configure(1'b0, 1'b1, 1'b1, 1'b1, 8'd32);
        run_stream(1'b1, 1'b1, 64, 1'b0, 1'b0);
        chk(stream_matches(1'b1, 64), "R2 demodulator 4-level bytes", rx[2], byte_at(0, 1'b1));

        // R4: demodulator source disabled
        configure(1'b0, 1'b0, 1'b1, 1'b0, 8'd32);
        run_stream(1'b1, 1'b1, 48, 1'b0, 1'b1);
        all_zero = (rx_count >= 4);
        for (int k = 0; k < rx_count; k++) if (rx[k] != 8'h00) all_zero = 1'b0;
        chk(all_zero, "R4 disabled demodulator gives zero bytes", rx[1], 0);

        // R3: filter mode removes single-sample glitches
        configure(1'b1, 1'b0, 1'b0, 1'b0, 8'd32);
        run_stream(1'b0, 1'b0, 96, 1'b1, 1'b1);
        chk(stream_matches(1'b0, 96), "R3 filtered 2-level bytes", rx[2], byte_at(0, 1'b0));
        configure(1'b1, 1'b0, 1'b1, 1'b0, 8'd32);
        run_stream(1'b1, 1'b0, 64, 1'b1, 1'b1);
        chk(stream_matches(1'b1, 64), "R3 filtered 4-level bytes", rx[2], byte_at(0, 1'b1));

        // R9: step 31 against 8-sample symbols must stay locked
        configure(1'b1, 1'b1, 1'b0, 1'b0, 8'd31);
        run_stream(1'b0, 1'b0, 160, 1'b0, 1'b1);
        chk(stream_matches(1'b0, 160), "R9 tracking under drift", rx[2], byte_at(0, 1'b0));

        // R7: byte pulse spacing
        ready_gap(1'b0, 64, "R7 2-level ready spacing");
        ready_gap(1'b1, 32, "R7 4-level ready spacing");

        // R8: recovered clock period
        clk_rises(8'd32, 32);
        clk_rises(8'd64, 64);

        // R10: disabled recovery stays idle while data toggles
        configure(1'b1, 1'b1, 1'b1, 1'b0, 8'd64);
        bad = 0;
        repeat (64) begin
            {pin_i, pin_q} = 2'($urandom);
            @(negedge clk);
            if (sym_ready || rec_clk || sym_reg != 8'h00) bad++;
        end
        chk(bad == 0, "R10 idle while rec_en low", bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule